// File: doc/BRIEF.md
# Autobauding Serial Receiver

This block receives asynchronous 8N1 serial data (8 data bits, LSB first, one stop bit, no parity) on the line that an operator's terminal drives. No baud rate is programmed into it. After reset or a relearn request it waits for the operator to press the space bar several times. For each space character it measures the first low interval on the line. That interval covers the start bit and data bits 0 to 4, so it lasts six bit times. The measurement is compared against one window per supported rate, and the receiver locks once enough consecutive spaces agree.

Once locked, the receiver samples every bit at its midpoint using the learned bit period. It presents each good byte with a one-cycle strobe. A frame whose stop bit reads low is reported as a framing error instead of a byte. Pulsing the relearn input drops the lock and starts detection again, for example after the terminal's speed has changed.

Top module: `uart_autobaud_rx`

## Requirements
- R1: With the receiver locked, a frame whose stop bit is high produces exactly one cycle of `rx_valid`, with `rx_data` holding the 8 data bits (first bit received in bit 0).
- R2: With the receiver locked, a frame whose stop bit samples low produces a one-cycle `frame_err` pulse and no `rx_valid` for that frame.
- R3: The supported rates are 1200, 2400, 4800 and 9600 baud. `rate` reports them as codes 0, 1, 2 and 3 respectively, with a bit period of round(`CLK_HZ`/baud) cycles.
- R4: A space measurement is accepted for a rate when the first low interval, in clock cycles, lies within ±`TOL_PCT` percent of six bit periods of that rate.
- R5: A measurement inside no window is discarded and breaks the run of agreeing measurements. Detection resumes once the line has been idle high for 11 bit periods of the slowest rate.
- R6: `locked` rises only after `MATCH_NEED` (default 2) consecutive accepted measurements give the same rate. A measurement giving a different rate starts a new run.
- R7: While `locked` is low, `rx_valid` and `frame_err` stay low, including during the learning spaces themselves.
- R8: A `relearn` pulse clears `locked` on the next clock and returns the block to rate detection. A new rate can then be learned.
- R9: After reset, `locked`, `rx_valid` and `frame_err` are low.
- R10: When locked, a low pulse on the line that has ended by the middle of the start bit is rejected as a false start and produces no output.
- R11: While `locked` stays high, `rate` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of frequency `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line from the terminal, idle high |
| relearn | input | 1 | One-cycle request to drop the lock and detect again |
| locked | output | 1 | High once a rate has been learned |
| rate | output | 2 | Learned rate code (0=1200, 1=2400, 2=4800, 3=9600) |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |
| rx_valid | output | 1 | One-cycle strobe for a good byte |
| frame_err | output | 1 | One-cycle strobe for a frame with a low stop bit |

## Verification
The bench builds the block with `CLK_HZ` = 192000, `TOL_PCT` = 12, `MATCH_NEED` = 2 and two synchronizer stages. With those values the bit periods are exactly 160, 80, 40 and 20 cycles, so learning and receiving at all four rates fits in a short run. The small periods also let the bench place spaces just inside the 9600 window (22-cycle bits, 132 low cycles) and just outside it (23-cycle bits, 138 low cycles). A scoreboard matches every byte and framing error against what was sent. Any output while unlocked, after a false start or during learning shows up as an unexpected item.

// File: rtl/uart_ab_pkg.sv
package uart_ab_pkg;

   localparam int unsigned NRATE     = 4;
   localparam int unsigned BASE_BAUD = 1200;

   typedef logic [1:0] rate_t;

   typedef enum logic [1:0] {
      M_IDLE,
      M_LOW,
      M_GUARD,
      M_WAIT
   } meter_st_e;

   typedef enum logic [1:0] {
      D_IDLE,
      D_START,
      D_DATA,
      D_STOP
   } deframe_st_e;

   // rounded clock cycles per bit for rate index idx (baud = BASE_BAUD << idx)
   function automatic int unsigned bit_cycles(input longint unsigned clk_hz,
                                              input int unsigned idx);
      longint unsigned baud;
      baud = 64'(BASE_BAUD) << idx;
      return 32'((clk_hz + baud / 64'd2) / baud);
   endfunction

endpackage

// File: rtl/uart_ab_sync.sv
module uart_ab_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_ab_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/uart_ab_meter.sv
module uart_ab_meter
   import uart_ab_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned TOL_PCT    = 12,
   parameter int unsigned MATCH_NEED = 2,
   parameter int unsigned SPACE_LOW  = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  line,
   input  logic  relearn,
   output logic  locked,
   output rate_t rate
);

   localparam int unsigned P_SLOW   = bit_cycles(64'(CLK_HZ), 0);
   localparam int unsigned P_FAST   = bit_cycles(64'(CLK_HZ), NRATE - 1);
   localparam int unsigned MEAS_MAX = (SPACE_LOW * P_SLOW * (100 + TOL_PCT)) / 100 + 1;
   localparam int unsigned GAP      = 11 * P_SLOW;
   localparam int unsigned CW       = $clog2(GAP + 1);
   localparam int unsigned MW       = $clog2(MATCH_NEED + 1);
   localparam logic [CW-1:0] MEAS_LIM = CW'(MEAS_MAX);
   localparam logic [CW-1:0] GAP_LIM  = CW'(GAP);
   localparam logic [MW-1:0] NEED     = MW'(MATCH_NEED);

   generate
      if (TOL_PCT >= 33) begin : g_bad_tol
         $error("uart_ab_meter: TOL_PCT must stay below 33 so rate windows do not overlap");
      end
      if (MATCH_NEED < 1) begin : g_bad_match
         $error("uart_ab_meter: MATCH_NEED must be at least 1");
      end
      if (P_FAST < 8) begin : g_bad_clk
         $error("uart_ab_meter: CLK_HZ too low for the fastest rate");
      end
      if (SPACE_LOW < 1) begin : g_bad_low
         $error("uart_ab_meter: SPACE_LOW must be at least 1");
      end
   endgenerate

   // acceptance windows and post-measurement guard lengths per rate
   logic [CW-1:0]    lo_tab    [NRATE];
   logic [CW-1:0]    hi_tab    [NRATE];
   logic [CW-1:0]    guard_tab [NRATE];
   logic [NRATE-1:0] hit;
   logic [CW-1:0]    cnt_q;

   for (genvar g = 0; g < NRATE; g++) begin : g_win
      localparam int unsigned PG  = bit_cycles(64'(CLK_HZ), g);
      localparam int unsigned NOM = SPACE_LOW * PG;
      assign lo_tab[g]    = CW'((NOM * (100 - TOL_PCT)) / 100);
      assign hi_tab[g]    = CW'((NOM * (100 + TOL_PCT)) / 100);
      // from the end of the low interval to mid stop bit: 3.5 bit times
      assign guard_tab[g] = CW'(3 * PG + PG / 2);
      assign hit[g]       = (cnt_q >= lo_tab[g]) && (cnt_q <= hi_tab[g]);
   end

   logic  hit_any;
   rate_t hit_idx;

   always_comb begin
      hit_any = |hit;
      hit_idx = '0;
      for (int i = 0; i < NRATE; i++) begin
         if (hit[i]) hit_idx = rate_t'(i);
      end
   end

   meter_st_e       st_q;
   rate_t           cand_q;
   logic [MW-1:0]   mcnt_q;
   logic            lock_q;
   rate_t           rate_q;
   logic            line_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= M_IDLE;
         cnt_q  <= '0;
         cand_q <= '0;
         mcnt_q <= '0;
         lock_q <= 1'b0;
         rate_q <= '0;
         line_d <= 1'b1;
      end else begin
         line_d <= line;
         if (relearn) begin
            st_q   <= M_IDLE;
            cnt_q  <= '0;
            mcnt_q <= '0;
            lock_q <= 1'b0;
         end else begin
            case (st_q)
               M_IDLE: begin
                  if (!lock_q && line_d && !line) begin
                     st_q  <= M_LOW;
                     cnt_q <= CW'(1);
                  end
               end
               M_LOW: begin
                  if (line) begin
                     if (hit_any) begin
                        st_q   <= M_GUARD;
                        cnt_q  <= guard_tab[hit_idx];
                        cand_q <= hit_idx;
                        if (mcnt_q != '0 && cand_q == hit_idx) begin
                           if (mcnt_q != NEED) mcnt_q <= mcnt_q + 1'b1;
                        end else begin
                           mcnt_q <= MW'(1);
                        end
                     end else begin
                        st_q   <= M_WAIT;
                        cnt_q  <= '0;
                        mcnt_q <= '0;
                     end
                  end else if (cnt_q >= MEAS_LIM) begin
                     st_q   <= M_WAIT;
                     cnt_q  <= '0;
                     mcnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               M_GUARD: begin
                  if (cnt_q <= CW'(1)) begin
                     st_q <= M_IDLE;
                     if (mcnt_q >= NEED) begin
                        lock_q <= 1'b1;
                        rate_q <= cand_q;
                        mcnt_q <= '0;
                     end
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               default: begin
                  if (!line)               cnt_q <= '0;
                  else if (cnt_q >= GAP_LIM) st_q <= M_IDLE;
                  else                     cnt_q <= cnt_q + 1'b1;
               end
            endcase
         end
      end
   end

   assign locked = lock_q;
   assign rate   = rate_q;

   // lock is only granted at the end of a measurement's guard period
   p_lock_from_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(st_q) == M_GUARD);

   // relearn always leaves the block unlocked
   p_relearn_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      relearn |=> !lock_q);

   // no measurement is taken while locked
   p_idle_when_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && $past(lock_q)) |-> st_q == M_IDLE);

endmodule

// File: rtl/uart_ab_deframer.sv
module uart_ab_deframer
   import uart_ab_pkg::*;
#(
   parameter int unsigned CLK_HZ = 50_000_000,
   parameter int unsigned DBITS  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             line,
   input  rate_t            rate,
   output logic [DBITS-1:0] data,
   output logic             vld,
   output logic             ferr
);

   localparam int unsigned P_SLOW = bit_cycles(64'(CLK_HZ), 0);
   localparam int unsigned CW     = $clog2(P_SLOW + 1);
   localparam int unsigned BW     = $clog2(DBITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(DBITS - 1);

   generate
      if (DBITS < 2) begin : g_bad_bits
         $error("uart_ab_deframer: DBITS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] per_tab [NRATE];

   for (genvar g = 0; g < NRATE; g++) begin : g_per
      assign per_tab[g] = CW'(bit_cycles(64'(CLK_HZ), g));
   end

   logic [CW-1:0] per;
   logic [CW-1:0] half;

   assign per  = per_tab[rate];
   assign half = per >> 1;

   deframe_st_e      st_q;
   logic [CW-1:0]    cnt_q;
   logic [BW-1:0]    bit_q;
   logic [DBITS-1:0] sh_q;
   logic [DBITS-1:0] data_q;
   logic             vld_q;
   logic             ferr_q;
   logic             line_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= D_IDLE;
         cnt_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         data_q <= '0;
         vld_q  <= 1'b0;
         ferr_q <= 1'b0;
         line_d <= 1'b1;
      end else begin
         line_d <= line;
         vld_q  <= 1'b0;
         ferr_q <= 1'b0;
         if (!en) begin
            st_q <= D_IDLE;
         end else begin
            case (st_q)
               D_IDLE: begin
                  if (line_d && !line) begin
                     st_q  <= D_START;
                     cnt_q <= half - 1'b1;
                  end
               end
               D_START: begin
                  if (cnt_q == '0) begin
                     if (!line) begin
                        st_q  <= D_DATA;
                        cnt_q <= per - 1'b1;
                        bit_q <= '0;
                     end else begin
                        st_q <= D_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               D_DATA: begin
                  if (cnt_q == '0) begin
                     sh_q  <= {line, sh_q[DBITS-1:1]};
                     cnt_q <= per - 1'b1;
                     if (bit_q == LAST_BIT) st_q <= D_STOP;
                     else                   bit_q <= bit_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
               default: begin
                  if (cnt_q == '0) begin
                     if (line) begin
                        vld_q  <= 1'b1;
                        data_q <= sh_q;
                     end else begin
                        ferr_q <= 1'b1;
                     end
                     st_q <= D_IDLE;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign data = data_q;
   assign vld  = vld_q;
   assign ferr = ferr_q;

   // an output strobe only follows a cycle in which reception was enabled
   p_out_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q || ferr_q) |-> $past(en));

   // a good byte is announced for one cycle only
   p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);

   // a framing error is reported from the stop-bit state only
   p_ferr_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_q |-> $past(st_q) == D_STOP);

endmodule

// File: rtl/uart_autobaud_rx.sv
module uart_autobaud_rx
   import uart_ab_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TOL_PCT     = 12,
   parameter int unsigned MATCH_NEED  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   input  logic       relearn,
   output logic       locked,
   output logic [1:0] rate,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       frame_err
);

   logic  line;
   logic  lock_w;
   rate_t rate_w;

   uart_ab_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (line)
   );

   uart_ab_meter #(
      .CLK_HZ     (CLK_HZ),
      .TOL_PCT    (TOL_PCT),
      .MATCH_NEED (MATCH_NEED),
      .SPACE_LOW  (6)
   ) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (line),
      .relearn (relearn),
      .locked  (lock_w),
      .rate    (rate_w)
   );

   uart_ab_deframer #(
      .CLK_HZ (CLK_HZ),
      .DBITS  (8)
   ) u_deframer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lock_w),
      .line  (line),
      .rate  (rate_w),
      .data  (rx_data),
      .vld   (rx_valid),
      .ferr  (frame_err)
   );

   assign locked = lock_w;
   assign rate   = rate_w;

   // a byte and a framing error never come from the same frame
   p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && frame_err));

   // the learned rate holds for as long as the lock does
   p_rate_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(rate));

   // nothing is delivered while unlocked
   p_quiet_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !(rx_valid || frame_err));

endmodule

// File: tb/uart_autobaud_rx_bench.sv
`timescale 1ns/1ps
module uart_autobaud_rx_bench;

   localparam int unsigned CLK_HZ = 192_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       relearn = 1'b0;
   logic       locked;
   logic [1:0] rate;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       frame_err;

   int checks = 0;
   int errors = 0;

   // bit 8 set means a framing error is expected, otherwise a byte
   logic [8:0] exp_q [$];
   logic [8:0] got;
   logic [8:0] want;

   always #2.5 clk = ~clk;

   uart_autobaud_rx #(
      .CLK_HZ      (CLK_HZ),
      .SYNC_STAGES (2),
      .TOL_PCT     (12),
      .MATCH_NEED  (2)
   ) u_uart_autobaud_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .relearn   (relearn),
      .locked    (locked),
      .rate      (rate),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .frame_err (frame_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic idle(input int n);
      rxd = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input int p, input bit stop_hi);
      rxd = 1'b0;
      repeat (p) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (p) @(negedge clk);
      end
      rxd = stop_hi;
      repeat (p) @(negedge clk);
      idle(3 * p);
   endtask

   task automatic send_space(input int p);
      send_frame(8'h20, p, 1'b1);
   endtask

   task automatic send_byte(input logic [7:0] b, input int p);
      exp_q.push_back({1'b0, b});
      send_frame(b, p, 1'b1);
   endtask

   task automatic send_bad_stop(input logic [7:0] b, input int p);
      exp_q.push_back(9'h100);
      send_frame(b, p, 1'b0);
   endtask

   task automatic pulse_relearn();
      relearn = 1'b1;
      @(negedge clk);
      relearn = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (rx_valid || frame_err)) begin
         got = frame_err ? 9'h100 : {1'b0, rx_data};
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R7/R10 unexpected output actual=%h expected=none", got);
         end else begin
            want = exp_q.pop_front();
            if (got !== want) begin
               errors++;
               $display("FAIL R1/R2 output actual=%h expected=%h", got, want);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (190_000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(locked == 1'b0, "R9 locked after reset", locked, 0);
      chk(rx_valid == 1'b0, "R9 rx_valid after reset", rx_valid, 0);
      chk(frame_err == 1'b0, "R9 frame_err after reset", frame_err, 0);
      idle(50);

      // R6/R7: one space is not enough, two lock at 9600 (code 3)
      send_space(20);
      chk(locked == 1'b0, "R6 single space no lock", locked, 0);
      send_space(20);
      chk(locked == 1'b1, "R6 two spaces lock", locked, 1);
      chk(rate == 2'd3, "R3 rate code 9600", rate, 3);

      // R1: several byte patterns
      send_byte(8'h55, 20);
      send_byte(8'hA3, 20);
      send_byte(8'h00, 20);
      send_byte(8'hFF, 20);

      // R2: low stop bit, then recovery
      send_bad_stop(8'h3C, 20);
      idle(40);
      send_byte(8'h96, 20);

      // R10: short low glitch is a false start
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      idle(100);
      send_byte(8'h81, 20);
      chk(rate == 2'd3, "R11 rate held while locked", rate, 3);

      // R8: relearn clears lock next cycle
      pulse_relearn();
      chk(locked == 1'b0, "R8 relearn clears lock", locked, 0);

      // R5: a bad measurement breaks the pair
      send_space(80);
      chk(locked == 1'b0, "R7 single space after relearn", locked, 0);
      send_space(30);
      idle(2000);
      send_space(80);
      chk(locked == 1'b0, "R5 bad measurement breaks pair", locked, 0);
      send_space(80);
      chk(locked == 1'b1, "R4 lock at 2400", locked, 1);
      chk(rate == 2'd1, "R3 rate code 2400", rate, 1);
      send_byte(8'h5A, 80);

      // R6: mismatched rates restart the run
      pulse_relearn();
      send_space(20);
      send_space(40);
      chk(locked == 1'b0, "R6 mismatch no lock", locked, 0);
      send_space(40);
      chk(locked == 1'b1, "R6 lock after restart", locked, 1);
      chk(rate == 2'd2, "R3 rate code 4800", rate, 2);
      send_byte(8'hC3, 40);

      // R3: slowest rate
      pulse_relearn();
      send_space(160);
      send_space(160);
      chk(locked == 1'b1, "R3 lock at 1200", locked, 1);
      chk(rate == 2'd0, "R3 rate code 1200", rate, 0);
      send_byte(8'h7E, 160);

      // R4/R5: window edges for 9600 (132 low cycles in, 138 out)
      pulse_relearn();
      send_space(23);
      idle(2000);
      send_space(23);
      idle(2000);
      chk(locked == 1'b0, "R5 out of window discarded", locked, 0);
      send_space(22);
      send_space(22);
      chk(locked == 1'b1, "R4 inside window accepted", locked, 1);
      chk(rate == 2'd3, "R4 snapped to 9600", rate, 3);
      send_byte(8'h4D, 20);

      idle(50);
      chk(exp_q.size() == 0, "R1 all expected outputs seen", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule